// File: doc/BRIEF.md
# Dual Saturating Accumulator

This block holds two 40-bit accumulators, called A and B, that share one 40-bit adder/subtracter. Each accumulator has a 32-bit main field and 8 guard bits above it. On each accepted operation one accumulator is both the source and the destination. The adder can add a 40-bit operand to it or subtract the operand from it. It can also load the operand, which is an add with the accumulator side forced to zero. Subtraction feeds the adder the complemented operand and an active-low borrow input, so the borrow stays inactive and the carry-in is one.

Each result is checked for two kinds of overflow. A guard-bit overflow means bits 39..31 of the raw result disagree. A catastrophic overflow means the true sign was lost out of bit 39. When saturation is enabled for the target accumulator, the result is clamped. A shared mode bit sets the clamp point: bit 31 gives 0x007FFFFFFF or 0xFF80000000, and bit 39 gives 0x7FFFFFFFFF or 0x8000000000. The direction of the clamp follows the true sign of the sum.

Per-accumulator flags track the last overflow and catastrophic overflow. Sticky saturation flags hold until they are cleared. A trap request combines the overflow flags with per-accumulator trap enables.

Top module: `dual_acc_sat`

## Requirements
- R1: When `op_valid` is high at a rising edge, `op_code` selects the operation: 0 adds, 1 subtracts and 2 loads. The accumulator picked by `acc_sel` (0 = A, 1 = B) takes the 40-bit two's-complement result, wrapped when not saturated, on that edge. The other accumulator does not change. Code 3, or `op_valid` low, changes no accumulator and no flag.
- R2: On each write to an accumulator, its overflow flag (`ovf_a`/`ovf_b`) becomes 1 exactly when bits 39..31 of the raw adder result are not all equal. Otherwise it becomes 0. The value is taken before any clamping.
- R3: On each write, the catastrophic flag (`cat_a`/`cat_b`) becomes 1 exactly when the true 41-bit result does not fit in 40 signed bits.
- R4: With the target's saturation enable high and `sat_at_39` low, a result with guard or catastrophic overflow is written as 0x007FFFFFFF if the true sign is positive, or as 0xFF80000000 if it is negative.
- R5: With the target's saturation enable high and `sat_at_39` high, only a catastrophic overflow clamps the result, to 0x7FFFFFFFFF or 0x8000000000 by true sign. A result with guard-only overflow is written unchanged.
- R6: With the target's saturation enable low, the result wraps with no clamping, and the target's saturation flag is not set.
- R7: `sat_a`/`sat_b` become 1 on the edge where their accumulator is clamped. They stay 1 until an edge with `clr_sat` high clears both. A clamp on the same edge as a clear leaves that flag set.
- R8: `ovf_any` is the OR of `ovf_a` and `ovf_b`, and `sat_any` is the OR of `sat_a` and `sat_b`.
- R9: `trap_req` is high in any cycle where (`ovf_a` and `trap_en_a`) or (`ovf_b` and `trap_en_b`) holds. It follows the enables in the same cycle.
- R10: Synchronous active-high `rst` clears both accumulators and every flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 add, 1 subtract, 2 load, 3 no operation |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| operand | input | 40 | Data operand |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_at_39 | input | 1 | Clamp point: 0 = bit 31, 1 = bit 39 |
| trap_en_a | input | 1 | Trap enable for A overflow |
| trap_en_b | input | 1 | Trap enable for B overflow |
| clr_sat | input | 1 | Clears both sticky saturation flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A guard-bit overflow, last write |
| ovf_b | output | 1 | B guard-bit overflow, last write |
| ovf_any | output | 1 | OR of the overflow flags |
| cat_a | output | 1 | A catastrophic overflow, last write |
| cat_b | output | 1 | B catastrophic overflow, last write |
| sat_a | output | 1 | A sticky saturation flag |
| sat_b | output | 1 | B sticky saturation flag |
| sat_any | output | 1 | OR of the saturation flags |
| trap_req | output | 1 | Overflow trap request |

## Verification
The accumulator value and the overflow, catastrophic and saturation flags are registered on the rising edge that samples the operation, so they are due one edge after the stimulus. `ovf_any`, `sat_any` and `trap_req` are combinational views of those registers; `trap_req` follows the trap enables with no added delay. The bench changes inputs on the falling edge, holds an operation for exactly one rising edge, and reads every output on the falling edge that follows. This read point is the first stable instant for both the registered and the combinational results.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [1:0] {
    DACC_ADD  = 2'd0,
    DACC_SUB  = 2'd1,
    DACC_LOAD = 2'd2,
    DACC_NOP  = 2'd3
  } dacc_op_e;
endpackage

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] opnd,
  input  dacc_pkg::dacc_op_e op,
  output logic [ACC_W-1:0] raw,
  output logic             true_sign,
  output logic             cat_ovf,
  output logic             guard_ovf
);
  localparam int MAIN_W = ACC_W - GUARD_W;
  localparam int TOP_W  = GUARD_W + 1;

  logic [ACC_W-1:0] side_a;
  logic [ACC_W-1:0] side_b;
  logic             borrow_n;
  logic             cin;
  logic [ACC_W:0]   sum;
  logic [TOP_W-1:0] top_bits;

  always_comb begin
    // zero-forced input turns the add into a load
    side_a   = (op == dacc_pkg::DACC_LOAD) ? '0 : acc_in;
    // subtract: complemented data, borrow inactive (active-low, so 1)
    side_b   = (op == dacc_pkg::DACC_SUB) ? ~opnd : opnd;
    borrow_n = 1'b1;
    cin      = (op == dacc_pkg::DACC_SUB) ? borrow_n : 1'b0;
    sum      = {side_a[ACC_W-1], side_a} + {side_b[ACC_W-1], side_b}
             + {{ACC_W{1'b0}}, cin};
    raw       = sum[ACC_W-1:0];
    true_sign = sum[ACC_W];
    cat_ovf   = sum[ACC_W] ^ sum[ACC_W-1];
    top_bits  = raw[ACC_W-1:MAIN_W-1];
    guard_ovf = !((&top_bits) || (~|top_bits));
  end
endmodule

// File: rtl/dacc_saturate.sv
module dacc_saturate #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic [ACC_W-1:0] raw,
  input  logic             true_sign,
  input  logic             cat_ovf,
  input  logic             guard_ovf,
  input  logic             sat_en,
  input  logic             at_top,
  output logic [ACC_W-1:0] res,
  output logic             sat_hit
);
  localparam int MAIN_W = ACC_W - GUARD_W;
  localparam logic [ACC_W-1:0] MAX_MAIN = {{(GUARD_W+1){1'b0}}, {(MAIN_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_MAIN = {{(GUARD_W+1){1'b1}}, {(MAIN_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] clamp;

  always_comb begin
    if (at_top) begin
      sat_hit = sat_en && cat_ovf;
      clamp   = true_sign ? MIN_FULL : MAX_FULL;
    end else begin
      sat_hit = sat_en && (cat_ovf || guard_ovf);
      clamp   = true_sign ? MIN_MAIN : MAX_MAIN;
    end
    res = sat_hit ? clamp : raw;
  end
endmodule

// File: rtl/dacc_bank.sv
module dacc_bank #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int N_ACC   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_ACC-1:0]            we,
  input  logic [ACC_W-1:0]            res,
  input  logic                        ovf_in,
  input  logic                        cat_in,
  input  logic                        sat_hit,
  input  logic                        clr_sat,
  input  logic [N_ACC-1:0]            sat_en,
  input  logic                        at_top,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_q,
  output logic [N_ACC-1:0]            ovf_q,
  output logic [N_ACC-1:0]            cat_q,
  output logic [N_ACC-1:0]            sat_q
);
  localparam int MAIN_W = ACC_W - GUARD_W;

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[i] <= '0;
        ovf_q[i] <= 1'b0;
        cat_q[i] <= 1'b0;
        sat_q[i] <= 1'b0;
      end else begin
        if (we[i]) begin
          acc_q[i] <= res;
          ovf_q[i] <= ovf_in;
          cat_q[i] <= cat_in;
        end
        if (we[i] && sat_hit) sat_q[i] <= 1'b1;
        else if (clr_sat)     sat_q[i] <= 1'b0;
      end
    end

    // R1: an accumulator that is not written keeps its value
    assert_hold_unselected_R1: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(acc_q[i]));

    // R2: overflow flag only moves on a write
    assert_ovf_on_write_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(ovf_q[i]) |-> $past(we[i]));

    // R4: saturating at bit 31 leaves guard bits equal to bit 31
    assert_main_clamp_R4: assert property (@(posedge clk) disable iff (rst)
      (we[i] && sat_en[i] && !at_top) |=>
        ((&acc_q[i][ACC_W-1:MAIN_W-1]) || (~|acc_q[i][ACC_W-1:MAIN_W-1])));

    // R7: sticky flag drops only through clear
    assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(sat_q[i]) |-> $past(clr_sat));
  end
endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat #(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic             acc_sel,
  input  logic [ACC_W-1:0] operand,
  input  logic             sat_en_a,
  input  logic             sat_en_b,
  input  logic             sat_at_39,
  input  logic             trap_en_a,
  input  logic             trap_en_b,
  input  logic             clr_sat,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             ovf_any,
  output logic             cat_a,
  output logic             cat_b,
  output logic             sat_a,
  output logic             sat_b,
  output logic             sat_any,
  output logic             trap_req
);
  localparam int N_ACC = 2;

  dacc_pkg::dacc_op_e     op;
  logic [N_ACC-1:0]       we;
  logic [N_ACC-1:0]       sat_en;
  logic [N_ACC-1:0][ACC_W-1:0] acc_q;
  logic [N_ACC-1:0]       ovf_q, cat_q, sat_q;
  logic [ACC_W-1:0]       src, raw, res;
  logic                   true_sign, cat_ovf, guard_ovf, sat_hit, do_op;

  always_comb begin
    op     = dacc_pkg::dacc_op_e'(op_code);
    do_op  = op_valid && (op != dacc_pkg::DACC_NOP);
    we     = {do_op && acc_sel, do_op && !acc_sel};
    sat_en = {sat_en_b, sat_en_a};
    src    = acc_q[acc_sel];
  end

  dacc_addsub #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_addsub (
    .acc_in(src), .opnd(operand), .op(op), .raw(raw),
    .true_sign(true_sign), .cat_ovf(cat_ovf), .guard_ovf(guard_ovf)
  );

  dacc_saturate #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_sat (
    .raw(raw), .true_sign(true_sign), .cat_ovf(cat_ovf), .guard_ovf(guard_ovf),
    .sat_en(sat_en[acc_sel]), .at_top(sat_at_39), .res(res), .sat_hit(sat_hit)
  );

  dacc_bank #(.ACC_W(ACC_W), .GUARD_W(GUARD_W), .N_ACC(N_ACC)) u_bank (
    .clk(clk), .rst(rst), .we(we), .res(res), .ovf_in(guard_ovf),
    .cat_in(cat_ovf), .sat_hit(sat_hit), .clr_sat(clr_sat), .sat_en(sat_en),
    .at_top(sat_at_39), .acc_q(acc_q), .ovf_q(ovf_q), .cat_q(cat_q), .sat_q(sat_q)
  );

  always_comb begin
    acc_a    = acc_q[0];
    acc_b    = acc_q[1];
    ovf_a    = ovf_q[0];
    ovf_b    = ovf_q[1];
    cat_a    = cat_q[0];
    cat_b    = cat_q[1];
    sat_a    = sat_q[0];
    sat_b    = sat_q[1];
    ovf_any  = |ovf_q;
    sat_any  = |sat_q;
    trap_req = (ovf_q[0] && trap_en_a) || (ovf_q[1] && trap_en_b);
  end

  // R9: a trap needs an overflow flag behind it
  assert_trap_source_R9: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (ovf_a || ovf_b));

  // R10: reset leaves both accumulators at zero
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (acc_a == '0 && acc_b == '0 && !sat_any));
endmodule

// File: tb/dual_acc_sat_test.sv
module dual_acc_sat_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, acc_sel, sat_en_a, sat_en_b, sat_at_39;
  logic        trap_en_a, trap_en_b, clr_sat;
  logic [1:0]  op_code;
  logic [39:0] operand, acc_a, acc_b;
  logic        ovf_a, ovf_b, ovf_any, cat_a, cat_b, sat_a, sat_b, sat_any, trap_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_acc_sat uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel),
    .operand(operand), .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .sat_at_39(sat_at_39),
    .trap_en_a(trap_en_a), .trap_en_b(trap_en_b), .clr_sat(clr_sat),
    .acc_a(acc_a), .acc_b(acc_b), .ovf_a(ovf_a), .ovf_b(ovf_b), .ovf_any(ovf_any),
    .cat_a(cat_a), .cat_b(cat_b), .sat_a(sat_a), .sat_b(sat_b), .sat_any(sat_any),
    .trap_req(trap_req)
  );

  localparam int NV = 13;
  localparam logic        V_SEL [NV] = '{0,0,0,1,1,1,0,0,0,0,1,1,0};
  localparam logic [1:0]  V_OP  [NV] = '{2,0,1,2,0,0,2,1,2,0,2,1,0};
  localparam logic [39:0] V_OPD [NV] = '{40'h0000001234, 40'h0000000010, 40'h0000001245,
    40'h007FFFFFFF, 40'h0000000001, 40'h0000000001, 40'h8000000000, 40'h0000000001,
    40'h7FFFFFFFFF, 40'h0000000001, 40'hFF80000000, 40'h0000000001, 40'h0100000000};
  localparam logic        V_SEN [NV] = '{0,0,0,0,0,1,0,1,0,0,1,1,1};
  localparam logic        V_M39 [NV] = '{0,0,0,0,0,0,0,1,0,0,0,0,0};
  localparam logic [39:0] V_RES [NV] = '{40'h0000001234, 40'h0000001244, 40'hFFFFFFFFFF,
    40'h007FFFFFFF, 40'h0080000000, 40'h007FFFFFFF, 40'h8000000000, 40'h8000000000,
    40'h7FFFFFFFFF, 40'h8000000000, 40'hFF80000000, 40'hFF80000000, 40'hFF80000000};
  localparam logic        V_OVF [NV] = '{0,0,0,0,1,1,1,1,1,1,0,1,1};
  localparam logic        V_SAT [NV] = '{0,0,0,0,0,1,0,1,1,1,1,1,1};
  localparam logic        V_CAT [NV] = '{0,0,0,0,0,0,0,1,0,1,0,0,0};

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic sel, input logic [1:0] code, input logic [39:0] d,
                       input logic sen, input logic m39, input logic clr);
    @(negedge clk);
    op_valid = 1'b1; acc_sel = sel; op_code = code; operand = d;
    sat_en_a = sen && !sel; sat_en_b = sen && sel; sat_at_39 = m39; clr_sat = clr;
    @(negedge clk);
    op_valid = 1'b0; clr_sat = 1'b0; sat_en_a = 1'b0; sat_en_b = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] exp_a, exp_b;
    logic        sa, sb;
    rst = 1'b1; op_valid = 1'b0; op_code = 2'd0; acc_sel = 1'b0; operand = '0;
    sat_en_a = 1'b0; sat_en_b = 1'b0; sat_at_39 = 1'b0;
    trap_en_a = 1'b0; trap_en_b = 1'b0; clr_sat = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 acc_a", acc_a, '0);
    chk("R10 acc_b", acc_b, '0);
    chk("R10 flags", {32'd0, ovf_a, ovf_b, cat_a, cat_b, sat_a, sat_b, trap_req, 1'b0}, '0);

    exp_a = '0; exp_b = '0; sa = 1'b0; sb = 1'b0;
    for (int v = 0; v < NV; v++) begin
      do_op(V_SEL[v], V_OP[v], V_OPD[v], V_SEN[v], V_M39[v], 1'b0);
      if (V_SEL[v]) exp_b = V_RES[v]; else exp_a = V_RES[v];
      // R1 result and untouched partner, R4/R5/R6 clamping
      chk($sformatf("R1/R4/R5/R6 vec%0d acc_a", v), acc_a, exp_a);
      chk($sformatf("R1 vec%0d acc_b", v), acc_b, exp_b);
      chk($sformatf("R2 vec%0d ovf", v), V_SEL[v] ? ovf_b : ovf_a, V_OVF[v]);
      chk($sformatf("R3 vec%0d cat", v), V_SEL[v] ? cat_b : cat_a, V_CAT[v]);
      chk($sformatf("R7 vec%0d sat", v), V_SEL[v] ? sat_b : sat_a, V_SAT[v]);
    end

    // R1: reserved code 3 writes nothing and keeps flags
    do_op(1'b0, 2'd3, 40'h0000000005, 1'b0, 1'b0, 1'b0);
    chk("R1 nop acc_a", acc_a, 40'hFF80000000);
    chk("R1 nop ovf_a", ovf_a, 1);
    // R8 OR flags
    chk("R8 ovf_any", ovf_any, 1);
    chk("R8 sat_any", sat_any, 1);
    // R9 trap gating
    trap_en_a = 1'b1; #1;
    chk("R9 trap a", trap_req, 1);
    trap_en_a = 1'b0; #1;
    chk("R9 trap off", trap_req, 0);
    // R7 clear
    @(negedge clk); clr_sat = 1'b1; @(negedge clk); clr_sat = 1'b0;
    chk("R7 clear sat_a", sat_a, 0);
    chk("R7 clear sat_b", sat_b, 0);
    chk("R8 sat_any cleared", sat_any, 0);
    chk("R7 clear keeps acc_b", acc_b, 40'hFF80000000);
    // R5 guard-only overflow passes at bit 39 clamp point
    do_op(1'b0, 2'd2, 40'h0100000000, 1'b1, 1'b1, 1'b0);
    chk("R5 guard only acc_a", acc_a, 40'h0100000000);
    chk("R5 guard only ovf_a", ovf_a, 1);
    chk("R5 guard only sat_a", sat_a, 0);
    // R9 trap through B, then drop after B overflow clears
    trap_en_b = 1'b1; #1;
    chk("R9 trap b", trap_req, 1);
    do_op(1'b1, 2'd2, 40'h0000000000, 1'b0, 1'b0, 1'b0);
    chk("R2 ovf_b cleared", ovf_b, 0);
    chk("R9 trap b gone", trap_req, 0);
    chk("R8 ovf_any a only", ovf_any, 1);
    trap_en_b = 1'b0;
    // R5 positive catastrophic clamp
    do_op(1'b0, 2'd2, 40'h7FFFFFFFFF, 1'b0, 1'b1, 1'b0);
    do_op(1'b0, 2'd0, 40'h0000000001, 1'b1, 1'b1, 1'b0);
    chk("R5 pos clamp acc_a", acc_a, 40'h7FFFFFFFFF);
    chk("R3 pos cat_a", cat_a, 1);
    chk("R7 pos sat_a", sat_a, 1);
    // R7 clamp and clear on the same edge: set wins for B, A cleared
    do_op(1'b1, 2'd2, 40'h0080000000, 1'b1, 1'b0, 1'b1);
    chk("R4 load clamp acc_b", acc_b, 40'h007FFFFFFF);
    chk("R7 set wins sat_b", sat_b, 1);
    chk("R7 clear sat_a", sat_a, 0);
    // R10 reset mid-run
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R10 rerun acc_a", acc_a, '0);
    chk("R10 rerun acc_b", acc_b, '0);
    chk("R10 rerun sat_any", sat_any, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule